// File: doc/BRIEF.md
# Byte Arithmetic Logic Unit with Status Flags

This block is the combinational datapath of a small 8-bit processor core. It takes two operand bytes and a five-bit operation code and returns a result byte. It also works out a new set of six condition flags: carry/borrow, zero, negative, overflow, sign and half-carry.

A small status register holds the flags between operations. It loads only when the flag write enable is high. The incoming carry and the incoming zero flag used by the chained operations come from this register. This lets a multi-byte add, subtract or equality compare be built as a sequence of single-byte operations.

A write-back qualifier tells the surrounding datapath whether the result should be stored. Compares and unused codes leave it low.

Top module: `flag_alu`

## Requirements
- R1: ADD (op 0) returns a+b and ADC (op 1) returns a+b+C. Carry (status bit 0) is the carry out of bit 7. Half-carry (status bit 5) is the carry out of bit 3. Overflow (status bit 3) is set when both operands share a sign that the result does not have.
- R2: SUB (op 2) returns a-b and SBC (op 3) returns a-b-C. Carry is set when a borrow is needed out of bit 7. Half-carry is set when a borrow is needed out of bit 3. Overflow is set when the operands differ in sign and the result sign differs from a.
- R3: After SBC (op 3) or CMPC (op 5), Z (status bit 1) keeps its previous value when the result is zero and is cleared when it is not. All other flag-updating operations set Z exactly when the result is zero.
- R4: CMP (op 4) and CMPC (op 5) produce the same flags as SUB and SBC with res_wr low. Every defined operation other than these two drives res_wr high.
- R5: INC (op 6) returns a+1 and DEC (op 7) returns a-1. Both leave carry and half-carry unchanged. Overflow is set only for INC of 0x7F and DEC of 0x80.
- R6: Every flag-updating operation sets N (status bit 2) to result bit 7 and S (status bit 4) to N XOR V.
- R7: AND (op 8), OR (op 9) and XOR (op 10) return the bitwise result, clear V, and leave C and H unchanged.
- R8: COM (op 11) returns ~a, sets C and clears V. NEG (op 12) returns 0-a, sets C when the result is non-zero, sets V when the result is 0x80, and sets H on a borrow out of bit 3.
- R9: SWAP (op 13) exchanges the two nibbles of a and changes no flag.
- R10: LSR (op 14) shifts in 0, ASR (op 15) repeats bit 7, and ROR (op 16) shifts the old C into bit 7. All three move bit 0 into C, set V to N XOR C, and leave H unchanged.
- R11: The status register resets to all zero. It loads the new flags on a clock edge only when flag_we is high and holds otherwise.
- R12: ADD and ADC with both operands equal act as a left shift and a rotate left through carry: C takes a bit 7 and H takes a bit 3.
- R13: Codes 17 to 31 return a unchanged, drive res_wr low and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | 8 | First operand (the destination operand) |
| b_in | input | 8 | Second operand |
| op_sel | input | 5 | Operation code |
| flag_we | input | 1 | Loads the new flags at the next clock edge |
| result | output | 8 | Combinational result byte |
| res_wr | output | 1 | High when the result should be written back |
| flag_q | output | 6 | Registered flags: bit0 C, bit1 Z, bit2 N, bit3 V, bit4 S, bit5 H |

## Verification
The interesting overlap is a chained operation that reads the status register in the same cycle the register is being loaded. An example is an SBC or CMPC issued right after a SUB whose borrow and zero flags are still being written, or an INC that follows a borrowing subtract. The bench provokes this with back-to-back chained sequences and with random streams in which flag_we toggles every cycle. It judges each cycle's result, write qualifier and subsequently registered flags against a behavioural integer model that carries its own copy of the flags from step to step.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBC  = 5'd3,
      OP_CMP  = 5'd4,
      OP_CMPC = 5'd5,
      OP_INC  = 5'd6,
      OP_DEC  = 5'd7,
      OP_AND  = 5'd8,
      OP_OR   = 5'd9,
      OP_XOR  = 5'd10,
      OP_COM  = 5'd11,
      OP_NEG  = 5'd12,
      OP_SWAP = 5'd13,
      OP_LSR  = 5'd14,
      OP_ASR  = 5'd15,
      OP_ROR  = 5'd16
   } alu_op_e;

   localparam int FLAG_W = 6;
   localparam int FC = 0;
   localparam int FZ = 1;
   localparam int FN = 2;
   localparam int FV = 3;
   localparam int FS = 4;
   localparam int FH = 5;

   typedef enum logic [2:0] {
      LG_AND  = 3'd0,
      LG_OR   = 3'd1,
      LG_XOR  = 3'd2,
      LG_NOT  = 3'd3,
      LG_SWAP = 3'd4
   } logic_sel_e;

   typedef enum logic [1:0] {
      SH_LOG = 2'd0,
      SH_ARI = 2'd1,
      SH_ROT = 2'd2
   } shift_sel_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W = 8,
   parameter int H_BIT  = 3,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [DATA_W-1:0] x_in,
   input  logic [DATA_W-1:0] y_in,
   input  logic              sub_en,
   input  logic              cin_en,
   input  logic              cin_flag,
   output logic [DATA_W-1:0] sum_out,
   output logic              carry_out,
   output logic              half_out,
   output logic              ovf_out
);
   localparam int LOW_W = H_BIT + 1;

   if (H_BIT < 0 || H_BIT >= DATA_W - 1) begin : g_bad_hbit
      $error("alu_addsub: H_BIT must lie below the top bit");
   end

   logic [DATA_W-1:0] y_eff;
   logic              c0;
   logic              c_raw;
   logic              h_raw;

   // subtraction is x + ~y + ~borrow_in; addition is x + y + carry_in
   assign y_eff = sub_en ? ~y_in : y_in;
   assign c0    = sub_en ^ (cin_en & cin_flag);

   if (RIPPLE) begin : g_ripple
      logic [DATA_W:0] ch;
      assign ch[0] = c0;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign sum_out[i] = x_in[i] ^ y_eff[i] ^ ch[i];
         assign ch[i+1]    = (x_in[i] & y_eff[i]) | ((x_in[i] ^ y_eff[i]) & ch[i]);
      end
      assign c_raw = ch[DATA_W];
      assign h_raw = ch[LOW_W];
   end else begin : g_flat
      assign {c_raw, sum_out} = {1'b0, x_in} + {1'b0, y_eff} + {{DATA_W{1'b0}}, c0};
      // carry into bit LOW_W recovered from the sum bit
      assign h_raw = x_in[LOW_W] ^ y_eff[LOW_W] ^ sum_out[LOW_W];
   end

   assign carry_out = c_raw ^ sub_en;
   assign half_out  = h_raw ^ sub_en;
   assign ovf_out   = (x_in[DATA_W-1] == y_eff[DATA_W-1]) &&
                      (sum_out[DATA_W-1] != x_in[DATA_W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic_sel_e        sel,
   output logic [DATA_W-1:0] res_out
);
   localparam int HALF = DATA_W / 2;

   if (DATA_W % 2 != 0) begin : g_bad_width
      $error("alu_logic: DATA_W must be even for the nibble exchange");
   end

   always_comb begin
      case (sel)
         LG_AND:  res_out = a_in & b_in;
         LG_OR:   res_out = a_in | b_in;
         LG_XOR:  res_out = a_in ^ b_in;
         LG_NOT:  res_out = ~a_in;
         LG_SWAP: res_out = {a_in[HALF-1:0], a_in[DATA_W-1:HALF]};
         default: res_out = a_in;
      endcase
   end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
   import alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_in,
   input  logic              cin_flag,
   input  shift_sel_e        sel,
   output logic [DATA_W-1:0] res_out,
   output logic              out_bit
);
   localparam int MSB = DATA_W - 1;

   logic fill;

   always_comb begin
      case (sel)
         SH_LOG:  fill = 1'b0;
         SH_ARI:  fill = a_in[MSB];
         default: fill = cin_flag;
      endcase
   end

   assign res_out = {fill, a_in[MSB:1]};
   assign out_bit = a_in[0];
endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int H_BIT  = 3,
   parameter bit RIPPLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic [4:0]        op_sel,
   input  logic              flag_we,
   output logic [DATA_W-1:0] result,
   output logic              res_wr,
   output logic [FLAG_W-1:0] flag_q
);
   localparam int MSB = DATA_W - 1;
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   if (DATA_W < 4 || DATA_W % 2 != 0) begin : g_bad_width
      $error("flag_alu: DATA_W must be even and at least 4");
   end

   alu_op_e op;
   assign op = alu_op_e'(op_sel);

   // ---------------- operand routing to the shared adder ----------------
   logic [DATA_W-1:0] as_x, as_y, as_sum;
   logic              as_sub, as_cin_en, as_c, as_h, as_v;

   always_comb begin
      as_x      = a_in;
      as_y      = b_in;
      as_sub    = 1'b0;
      as_cin_en = 1'b0;
      case (op)
         OP_ADC:          as_cin_en = 1'b1;
         OP_SUB, OP_CMP:  as_sub    = 1'b1;
         OP_SBC, OP_CMPC: begin
            as_sub    = 1'b1;
            as_cin_en = 1'b1;
         end
         OP_INC:          as_y = ONE;
         OP_DEC: begin
            as_y   = ONE;
            as_sub = 1'b1;
         end
         OP_NEG: begin
            as_x   = '0;
            as_y   = a_in;
            as_sub = 1'b1;
         end
         default: ;
      endcase
   end

   alu_addsub #(.DATA_W(DATA_W), .H_BIT(H_BIT), .RIPPLE(RIPPLE)) u_addsub (
      .x_in      (as_x),
      .y_in      (as_y),
      .sub_en    (as_sub),
      .cin_en    (as_cin_en),
      .cin_flag  (flag_q[FC]),
      .sum_out   (as_sum),
      .carry_out (as_c),
      .half_out  (as_h),
      .ovf_out   (as_v)
   );

   // ---------------- bitwise unit ----------------
   logic_sel_e        lg_sel;
   logic [DATA_W-1:0] lg_res;

   always_comb begin
      case (op)
         OP_OR:   lg_sel = LG_OR;
         OP_XOR:  lg_sel = LG_XOR;
         OP_COM:  lg_sel = LG_NOT;
         OP_SWAP: lg_sel = LG_SWAP;
         default: lg_sel = LG_AND;
      endcase
   end

   alu_logic #(.DATA_W(DATA_W)) u_logic (
      .a_in    (a_in),
      .b_in    (b_in),
      .sel     (lg_sel),
      .res_out (lg_res)
   );

   // ---------------- right shifter ----------------
   shift_sel_e        sh_sel;
   logic [DATA_W-1:0] sh_res;
   logic              sh_out;

   always_comb begin
      case (op)
         OP_LSR:  sh_sel = SH_LOG;
         OP_ASR:  sh_sel = SH_ARI;
         default: sh_sel = SH_ROT;
      endcase
   end

   alu_shift #(.DATA_W(DATA_W)) u_shift (
      .a_in     (a_in),
      .cin_flag (flag_q[FC]),
      .sel      (sh_sel),
      .res_out  (sh_res),
      .out_bit  (sh_out)
   );

   // ---------------- result select and flag update ----------------
   logic [FLAG_W-1:0] nf;
   logic [DATA_W-1:0] res_c;
   logic              wr_c, upd_nzs, chain_z, res_zero;

   always_comb begin
      nf       = flag_q;
      res_c    = a_in;
      wr_c     = 1'b0;
      upd_nzs  = 1'b0;
      chain_z  = (op == OP_SBC) || (op == OP_CMPC);
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG: begin
            res_c   = as_sum;
            nf[FC]  = as_c;
            nf[FH]  = as_h;
            nf[FV]  = as_v;
            upd_nzs = 1'b1;
            wr_c    = (op != OP_CMP) && (op != OP_CMPC);
         end
         OP_INC, OP_DEC: begin
            res_c   = as_sum;
            nf[FV]  = as_v;
            upd_nzs = 1'b1;
            wr_c    = 1'b1;
         end
         OP_AND, OP_OR, OP_XOR: begin
            res_c   = lg_res;
            nf[FV]  = 1'b0;
            upd_nzs = 1'b1;
            wr_c    = 1'b1;
         end
         OP_COM: begin
            res_c   = lg_res;
            nf[FC]  = 1'b1;
            nf[FV]  = 1'b0;
            upd_nzs = 1'b1;
            wr_c    = 1'b1;
         end
         OP_SWAP: begin
            res_c = lg_res;
            wr_c  = 1'b1;
         end
         OP_LSR, OP_ASR, OP_ROR: begin
            res_c   = sh_res;
            nf[FC]  = sh_out;
            nf[FV]  = sh_res[MSB] ^ sh_out;
            upd_nzs = 1'b1;
            wr_c    = 1'b1;
         end
         default: ;
      endcase
      res_zero = (res_c == '0);
      if (upd_nzs) begin
         nf[FN] = res_c[MSB];
         nf[FZ] = chain_z ? (flag_q[FZ] & res_zero) : res_zero;
         nf[FS] = nf[FN] ^ nf[FV];
      end
   end

   assign result = res_c;
   assign res_wr = wr_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= '0;
      else if (flag_we) flag_q <= nf;
   end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
   import alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        op_sel,
   input logic              flag_we,
   input logic [DATA_W-1:0] result,
   input logic              res_wr,
   input logic [FLAG_W-1:0] flag_q
);
   logic flag_op;
   assign flag_op = (op_sel <= 5'd16) && (op_sel != 5'd13);

   // R6
   s_is_n_xor_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[FS] == (flag_q[FN] ^ flag_q[FV]));

   // R6
   n_tracks_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && flag_op) |=> flag_q[FN] == $past(result[DATA_W-1]));

   // R11
   hold_without_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we |=> $stable(flag_q));

   // R5
   incdec_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && (op_sel == 5'd6 || op_sel == 5'd7))
      |=> (flag_q[FC] == $past(flag_q[FC])) && (flag_q[FH] == $past(flag_q[FH])));

   // R4
   compare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 5'd4 || op_sel == 5'd5) |-> !res_wr);

   // R7
   logic_clears_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel >= 5'd8 && op_sel <= 5'd10) |=> !flag_q[FV]);

   // R8
   com_sets_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel == 5'd11) |=> flag_q[FC]);

   // R9
   swap_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel == 5'd13) |=> $stable(flag_q));

   // R13
   undefined_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel > 5'd16) |-> !res_wr);
endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) u_flag_alu_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op_sel  (op_sel),
   .flag_we (flag_we),
   .result  (result),
   .res_wr  (res_wr),
   .flag_q  (flag_q)
);

// File: tb/test_flag_alu.sv
module test_flag_alu;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] a_in = '0;
   logic [7:0] b_in = '0;
   logic [4:0] op_sel = '0;
   logic       flag_we = 1'b0;
   logic [7:0] result;
   logic       res_wr;
   logic [5:0] flag_q;

   int checks = 0;
   int failures = 0;
   logic [5:0] mflags = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flag_alu i_flag_alu (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .op_sel(op_sel),
      .flag_we(flag_we), .result(result), .res_wr(res_wr), .flag_q(flag_q)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // behavioural model; flags: bit0 C, 1 Z, 2 N, 3 V, 4 S, 5 H
   task automatic model(input int a, input int b, input int op, input logic [5:0] f,
                        output logic [7:0] res, output logic wr, output logic [5:0] nf);
      int c, r, hd, cin;
      logic v, n, upd, chain;
      c = int'(f[0]);
      nf = f; res = a[7:0]; wr = 0; upd = 1; chain = 0; v = 0;
      if (op == 0 || op == 1) begin
         cin = (op == 1) ? c : 0;
         r = a + b + cin; res = r[7:0];
         nf[0] = (r > 255); nf[5] = ((a % 16) + (b % 16) + cin) > 15;
         v = (a[7] == b[7]) && (res[7] != a[7]); wr = 1;
      end else if (op >= 2 && op <= 5) begin
         cin = (op % 2 == 1) ? c : 0;
         r = a - b - cin; res = r[7:0];
         nf[0] = (r < 0); hd = (a % 16) - (b % 16) - cin; nf[5] = (hd < 0);
         v = (a[7] != b[7]) && (res[7] != a[7]);
         wr = (op < 4); chain = (op % 2 == 1);
      end else if (op == 6) begin
         r = a + 1; res = r[7:0]; v = (a == 127); wr = 1;
      end else if (op == 7) begin
         r = a - 1; res = r[7:0]; v = (a == 128); wr = 1;
      end else if (op == 8) begin
         r = a & b; res = r[7:0]; wr = 1;
      end else if (op == 9) begin
         r = a | b; res = r[7:0]; wr = 1;
      end else if (op == 10) begin
         r = a ^ b; res = r[7:0]; wr = 1;
      end else if (op == 11) begin
         r = 255 - a; res = r[7:0]; nf[0] = 1; wr = 1;
      end else if (op == 12) begin
         r = (256 - a) % 256; res = r[7:0];
         nf[0] = (r != 0); v = (r == 128); nf[5] = (a % 16) != 0; wr = 1;
      end else if (op == 13) begin
         r = (a % 16) * 16 + a / 16; res = r[7:0]; wr = 1; upd = 0;
      end else if (op >= 14 && op <= 16) begin
         r = a / 2;
         if (op == 15 && a >= 128) r = r + 128;
         if (op == 16 && c == 1) r = r + 128;
         res = r[7:0]; nf[0] = a[0]; v = res[7] ^ a[0]; wr = 1;
      end else begin
         upd = 0;
      end
      if (upd) begin
         n = res[7];
         nf[2] = n; nf[3] = v; nf[4] = n ^ v;
         nf[1] = chain ? (f[1] && res == 8'h00) : (res == 8'h00);
      end
   endtask

   task automatic step(input string tag, input int a, input int b, input int op, input logic we);
      logic [7:0] er; logic ew; logic [5:0] enf;
      @(negedge clk);
      a_in = a[7:0]; b_in = b[7:0]; op_sel = op[4:0]; flag_we = we;
      #1;
      model(a, b, op, mflags, er, ew, enf);
      check(tag, "result", int'(result), int'(er));
      check(tag, "res_wr", int'(res_wr), int'(ew));
      @(posedge clk);
      if (we) mflags = enf;
      #1;
      check(tag, "flags", int'(flag_q), int'(mflags));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset value
      check("R11", "reset flags", int'(flag_q), 0);
      rst_n = 1'b1;
      // R1 add / add with carry
      step("R1", 8'h3A, 8'h46, 0, 1);
      step("R1", 8'hFF, 8'h01, 0, 1);
      step("R1", 8'h10, 8'h20, 1, 1);
      step("R1", 8'h7F, 8'h00, 1, 1);
      // R12 shift/rotate left as self-add
      step("R12", 8'h88, 8'h88, 0, 1);
      step("R12", 8'h41, 8'h41, 1, 1);
      // R2 subtract, borrow
      step("R2", 8'h10, 8'h01, 2, 1);
      step("R2", 8'h00, 8'h01, 2, 1);
      step("R2", 8'h80, 8'h01, 3, 1);
      // R3 chained zero: equal two-byte compare, then unequal low byte
      step("R3", 8'h34, 8'h34, 2, 1);
      step("R3", 8'h12, 8'h12, 3, 1);
      step("R3", 8'h00, 8'h01, 2, 1);
      step("R3", 8'h13, 8'h12, 3, 1);
      // R4 compare: no write-back
      step("R4", 8'h05, 8'h05, 4, 1);
      step("R4", 8'h05, 8'h05, 5, 1);
      step("R4", 8'h02, 8'h09, 4, 1);
      step("R4", 8'h09, 8'h02, 5, 1);
      // R5 inc/dec keep carry
      step("R5", 8'h00, 8'h01, 2, 1);
      step("R5", 8'h7F, 8'h00, 6, 1);
      step("R5", 8'h80, 8'h00, 7, 1);
      step("R5", 8'h01, 8'h00, 7, 1);
      step("R5", 8'hFF, 8'h00, 6, 1);
      // R7 logic keeps C and H
      step("R7", 8'hF0, 8'h3C, 8, 1);
      step("R7", 8'h80, 8'h01, 9, 1);
      step("R7", 8'h5A, 8'h5A, 10, 1);
      // R8 complement / negate
      step("R8", 8'hFF, 8'h00, 11, 1);
      step("R8", 8'h80, 8'h00, 12, 1);
      step("R8", 8'h00, 8'h00, 12, 1);
      step("R8", 8'h01, 8'h00, 12, 1);
      // R9 swap
      step("R9", 8'hA5, 8'h00, 13, 1);
      // R10 right shifts
      step("R10", 8'h01, 8'h00, 14, 1);
      step("R10", 8'h81, 8'h00, 15, 1);
      step("R10", 8'h02, 8'h00, 16, 1);
      step("R10", 8'h00, 8'h01, 2, 1);
      step("R10", 8'h03, 8'h00, 16, 1);
      // R11 write enable low holds flags
      step("R11", 8'h00, 8'h00, 0, 0);
      step("R11", 8'hFF, 8'hFF, 0, 0);
      // R13 undefined codes
      step("R13", 8'h77, 8'h11, 17, 1);
      step("R13", 8'h00, 8'h00, 31, 1);
      // R6 random stream with toggling write enable
      for (int i = 0; i < 3000; i++) begin
         step("R6", int'($urandom % 256), int'($urandom % 256), int'($urandom % 32),
              logic'($urandom % 2));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule